// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the general-purpose register file of a processor that gives each procedure its own window of registers. Software sees 32 logical registers. A window pointer selects which slice of a larger physical array backs them. Logical registers 0 to 9 are globals and are the same in every window. Registers 16 to 25 are private to the active window. Registers 10 to 15 and 26 to 31 are shared with the two neighbouring windows. A caller places arguments in its registers 26 to 31, and after a call the callee finds them in its registers 10 to 15 with no copying.

There are two combinational read ports and one clocked write port, all addressed by logical register number. A call strobe advances the window pointer by one window and a return strobe moves it back by one, wrapping around the ring. The block does not spill windows to memory. It keeps a count of saved windows and raises a one-cycle overflow flag when a call reuses a window whose contents are still owed to an older caller. It raises a one-cycle underflow flag when a return is made with no saved window. The physical address is `NGLOB + ((ptr*(NSHARE+NPRIV) + r - NGLOB) mod (NWIN*(NSHARE+NPRIV)))` for r at or above NGLOB, and r for globals. The defaults give 8 windows of 16 new registers plus 10 globals, which is 138 physical registers.

No port carries a stream, so there is no valid/ready handshake and no back-pressure. Reads answer in the same cycle. A write strobe is always accepted at the next clock edge. The call and return strobes are plain single-cycle controls.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, both flags are 0, and every logical register reads 0.
- R2: Logical register 0 always reads 0, and a write to it changes nothing.
- R3: Logical registers 1 to 9 map to the same physical registers whatever the window pointer is.
- R4: A lone call sets the window pointer to (ptr+1) mod NWIN at the next edge, and a lone return sets it to (ptr+NWIN-1) mod NWIN. With no strobe the pointer holds.
- R5: The registers 26 to 31 of the window at pointer p are the same storage as the registers 10 to 15 of the window at pointer p+1, in that order.
- R6: A write to registers 16 to 25 in one window is not visible through registers 16 to 25 of its neighbouring windows.
- R7: A write in the same cycle as a call or a return lands in the window that was active before the pointer moved.
- R8: Reads are combinational. A write becomes visible at the read ports from the cycle after its clock edge, and a read of the same register in the write cycle returns the old value.
- R9: The saved-window count starts at 0. A lone call when NWIN-2 windows are already saved still moves the pointer, leaves the count unchanged, and pulses win_ovf high for exactly one cycle. Otherwise a call adds one to the count.
- R10: A lone return when the saved-window count is 0 still moves the pointer back, and pulses win_unf high for exactly one cycle. Otherwise a return takes one from the count.
- R11: A call and a return in the same cycle cancel. The pointer, the count and both flags stay as if neither strobe were asserted.
- R12: The pointer wraps. After NWIN calls it is back at its starting value, and the window then shows the same contents it held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | LAW (5) | Logical register number, read port A |
| rd_data_a | output | XLEN (32) | Read data, port A |
| rd_addr_b | input | LAW (5) | Logical register number, read port B |
| rd_data_b | output | XLEN (32) | Read data, port B |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | LAW (5) | Logical register number to write |
| wr_data | input | XLEN (32) | Write data |
| call_i | input | 1 | Advance the window pointer by one |
| ret_i | input | 1 | Move the window pointer back by one |
| win_ptr | output | PW (3) | Current window pointer |
| win_ovf | output | 1 | One-cycle pulse: a call overran the saved windows |
| win_unf | output | 1 | One-cycle pulse: a return found no saved window |

## Verification
A wrong window pointer shows up at the read ports in the same cycle as the first read of any non-global register, because every windowed value then comes from another slice. It also shows on win_ptr one cycle after the faulty strobe. A wrong address map, such as a bad offset or wrap, shows as data that fails to cross a call. The first read of registers 10 to 15 after a call, or of 26 to 31 after a return, exposes it. A wrong saved-window count produces no visible effect until the call or return that should or should not have flagged. The flag is registered, so that edge is one cycle after the strobe. The bench therefore drives long call and return runs on top of a per-cycle comparison against a behavioural model.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
package rwin_pkg;

  // Motion of the window pointer decided from the two strobes.
  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_FWD  = 2'd1,
    MOVE_BACK = 2'd2
  } win_move_e;

  function automatic win_move_e decode_move(input logic call_s, input logic ret_s);
    if (call_s && !ret_s)      return MOVE_FWD;
    else if (ret_s && !call_s) return MOVE_BACK;
    else                       return MOVE_HOLD;
  endfunction

endpackage

// File: rtl/rwin_map.sv
`timescale 1ns/1ps
// Logical register number plus window pointer to physical index.
module rwin_map #(
  parameter int NWIN   = 8,
  parameter int NGLOB  = 10,
  parameter int NSHARE = 6,
  parameter int NPRIV  = 10,
  parameter int LAW    = 5,
  parameter int PW     = 3,
  parameter int PAW    = 8
) (
  input  logic [LAW-1:0] lreg,
  input  logic [PW-1:0]  ptr,
  output logic [PAW-1:0] preg
);
  localparam int NEW  = NSHARE + NPRIV;
  localparam int RING = NWIN * NEW;
  localparam int OW   = $clog2(2 * RING + 1);

  logic [OW-1:0] base;
  logic [OW-1:0] offs;
  logic [OW-1:0] wrapped;
  logic          is_glob;

  always_comb begin
    is_glob = (lreg < LAW'(NGLOB));
    base    = OW'(ptr) * OW'(NEW);
    offs    = base + OW'(lreg) - OW'(NGLOB);
    // offs stays below 2*RING, so one conditional subtract wraps it
    wrapped = (offs >= OW'(RING)) ? (offs - OW'(RING)) : offs;
    preg    = is_glob ? PAW'(lreg) : (PAW'(NGLOB) + PAW'(wrapped));
  end

endmodule

// File: rtl/rwin_ptr_ctl.sv
`timescale 1ns/1ps
// Window pointer, saved-window count and the two event flags.
module rwin_ptr_ctl
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  output logic [PW-1:0] ptr,
  output logic          ovf,
  output logic          unf
);
  localparam int DW = $clog2(NWIN);
  localparam logic [DW-1:0] DEPTH_MAX = DW'(NWIN - 2);
  localparam logic [PW-1:0] PTR_LAST  = PW'(NWIN - 1);

  logic [DW-1:0] depth;
  win_move_e     move;
  logic [PW-1:0] ptr_fwd;
  logic [PW-1:0] ptr_back;

  always_comb begin
    move     = decode_move(call_i, ret_i);
    ptr_fwd  = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    ptr_back = (ptr == '0) ? PTR_LAST : ptr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      depth <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      unique case (move)
        MOVE_FWD: begin
          ptr <= ptr_fwd;
          if (depth == DEPTH_MAX) ovf   <= 1'b1;
          else                    depth <= depth + 1'b1;
        end
        MOVE_BACK: begin
          ptr <= ptr_back;
          if (depth == '0) unf   <= 1'b1;
          else             depth <= depth - 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rwin_store.sv
`timescale 1ns/1ps
// Physical storage: NRD combinational read ports, one clocked write port.
module rwin_store #(
  parameter int XLEN  = 32,
  parameter int NPHYS = 138,
  parameter int PAW   = 8,
  parameter int NRD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][PAW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata,
  input  logic                      we,
  input  logic [PAW-1:0]            waddr,
  input  logic [XLEN-1:0]           wdata
);
  logic [XLEN-1:0] cells [NPHYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) cells[i] <= '0;
    end else if (we && (waddr != '0) && (waddr < PAW'(NPHYS))) begin
      cells[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if ((raddr[p] == '0) || (raddr[p] >= PAW'(NPHYS))) rdata[p] = '0;
      else                                                rdata[p] = cells[raddr[p]];
    end
  end

endmodule

// File: rtl/rwin_regfile.sv
`timescale 1ns/1ps
module rwin_regfile #(
  parameter int XLEN   = 32,
  parameter int NWIN   = 8,
  parameter int NGLOB  = 10,
  parameter int NSHARE = 6,
  parameter int NPRIV  = 10,
  localparam int LAW   = $clog2(NGLOB + 2 * NSHARE + NPRIV),
  localparam int PW    = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LAW-1:0]  rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [LAW-1:0]  rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [LAW-1:0]  wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            call_i,
  input  logic            ret_i,
  output logic [PW-1:0]   win_ptr,
  output logic            win_ovf,
  output logic            win_unf
);
  localparam int NPHYS = NGLOB + NWIN * (NSHARE + NPRIV);
  localparam int PAW   = $clog2(NPHYS);
  localparam int NRD   = 2;
  localparam int NMAP  = NRD + 1;   // read ports, then the write port

  logic [NMAP-1:0][LAW-1:0]  map_l;
  logic [NMAP-1:0][PAW-1:0]  map_p;
  logic [NRD-1:0][PAW-1:0]   rd_p;
  logic [NRD-1:0][XLEN-1:0]  rd_v;
  logic [PW-1:0]             ptr;

  assign map_l[0] = rd_addr_a;
  assign map_l[1] = rd_addr_b;
  assign map_l[2] = wr_addr;

  rwin_ptr_ctl #(.NWIN(NWIN), .PW(PW)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .call_i (call_i),
    .ret_i  (ret_i),
    .ptr    (ptr),
    .ovf    (win_ovf),
    .unf    (win_unf)
  );

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rwin_map #(
      .NWIN(NWIN), .NGLOB(NGLOB), .NSHARE(NSHARE), .NPRIV(NPRIV),
      .LAW(LAW), .PW(PW), .PAW(PAW)
    ) u_map (
      .lreg (map_l[m]),
      .ptr  (ptr),
      .preg (map_p[m])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rdp
    assign rd_p[p] = map_p[p];
  end

  rwin_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PAW(PAW), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (rd_p),
    .rdata (rd_v),
    .we    (wr_en),
    .waddr (map_p[NRD]),
    .wdata (wr_data)
  );

  assign rd_data_a = rd_v[0];
  assign rd_data_b = rd_v[1];
  assign win_ptr   = ptr;

endmodule

// File: rtl/rwin_regfile_chk.sv
`timescale 1ns/1ps
module rwin_regfile_chk #(
  parameter int XLEN = 32,
  parameter int NWIN = 8,
  parameter int LAW  = 5,
  parameter int PW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [LAW-1:0]  rd_addr_a,
  input logic [XLEN-1:0] rd_data_a,
  input logic [LAW-1:0]  rd_addr_b,
  input logic [XLEN-1:0] rd_data_b,
  input logic            call_i,
  input logic            ret_i,
  input logic [PW-1:0]   win_ptr,
  input logic            win_ovf,
  input logic            win_unf
);
  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NWIN - 1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
    return (p == '0) ? PW'(NWIN - 1) : p - 1'b1;
  endfunction

  assert_zero_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  assert_zero_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));
  assert_call_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i) |=> (win_ptr == nxt($past(win_ptr))));
  assert_ret_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=> (win_ptr == prv($past(win_ptr))));
  assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i == ret_i) |=> ($stable(win_ptr) && !win_ovf && !win_unf));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_ovf |-> $past(call_i && !ret_i));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_unf |-> $past(ret_i && !call_i));
  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_ovf, win_unf}));

endmodule

bind rwin_regfile rwin_regfile_chk #(.XLEN(XLEN), .NWIN(NWIN), .LAW(LAW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .win_ptr   (win_ptr),
  .win_ovf   (win_ovf),
  .win_unf   (win_unf)
);

// File: tb/rwin_regfile_tb.sv
`timescale 1ns/1ps
module rwin_regfile_tb;
  localparam int XLEN = 32;
  localparam int NWIN = 8;
  localparam int NG   = 10;
  localparam int NEWR = 16;
  localparam int RING = NWIN * NEWR;
  localparam int NPH  = NG + RING;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [XLEN-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic            wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [2:0]      win_ptr;
  logic            win_ovf, win_unf;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [XLEN-1:0] mm [NPH];
  int  cwp_m = 0, dep_m = 0;
  bit  ovf_m = 0, unf_m = 0;

  always #4 clk = ~clk;

  rwin_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_i(call_i), .ret_i(ret_i),
    .win_ptr(win_ptr), .win_ovf(win_ovf), .win_unf(win_unf)
  );

  function automatic int phys(int r, int c);
    if (r < NG) return r;
    return NG + ((c * NEWR + r - NG) % RING);
  endfunction

  function automatic logic [XLEN-1:0] mread(int r);
    if (r == 0) return '0;
    return mm[phys(r, cwp_m)];
  endfunction

  task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, int ra, int rb, bit we, int wa, logic [XLEN-1:0] wd,
                      bit c, bit r);
    @(negedge clk);
    rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
    wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    call_i = c; ret_i = r;
    #1;
    chk(tag, "read A", rd_data_a, mread(ra));
    chk(tag, "read B", rd_data_b, mread(rb));
    @(posedge clk);
    #1;
    if (we && wa != 0) mm[phys(wa, cwp_m)] = wd;
    ovf_m = 0; unf_m = 0;
    if (c && !r) begin
      cwp_m = (cwp_m + 1) % NWIN;
      if (dep_m == NWIN - 2) ovf_m = 1; else dep_m++;
    end else if (r && !c) begin
      cwp_m = (cwp_m + NWIN - 1) % NWIN;
      if (dep_m == 0) unf_m = 1; else dep_m--;
    end
    chk("R4", "win_ptr", XLEN'(win_ptr), XLEN'(cwp_m));
    chk("R9", "win_ovf", XLEN'(win_ovf), XLEN'(ovf_m));
    chk("R10", "win_unf", XLEN'(win_unf), XLEN'(unf_m));
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPH; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1", "ptr", XLEN'(win_ptr), '0);
    chk("R1", "ovf/unf", XLEN'({win_ovf, win_unf}), '0);
    step("R1", 1, 17, 0, 0, 0, 0, 0);
    step("R1", 31, 10, 0, 0, 0, 0, 0);

    // R2: register zero
    step("R2", 0, 0, 1, 0, 32'hA5A5_0001, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0);

    // R3: globals survive a call
    for (int g = 1; g < NG; g++) step("R3", g, 0, 1, g, 32'h100 + g, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 0);
    for (int g = 1; g < NG; g++) step("R3", g, g, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 1);

    // R5: caller high registers equal callee low registers
    for (int k = 26; k < 32; k++) step("R5", 0, 0, 1, k, 32'h2600 + k, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 0);
    for (int k = 10; k < 16; k++) step("R5", k, k + 16, 1, k, 32'h1000 + k, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1);
    for (int k = 26; k < 32; k++) step("R5", k, 0, 0, 0, 0, 0, 0);

    // R6: private registers stay private
    for (int k = 16; k < 26; k++) step("R6", 0, 0, 1, k, 32'h6000 + k, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1, 0);
    for (int k = 16; k < 26; k++) step("R6", k, 0, 1, k, 32'h7000 + k, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1);
    for (int k = 16; k < 26; k++) step("R6", k, 0, 0, 0, 0, 0, 0);

    // R7: write with call lands in the old window, write with return too
    step("R7", 0, 0, 1, 20, 32'h0000_0777, 1, 0);
    step("R7", 20, 0, 1, 21, 32'h0000_0888, 0, 1);
    step("R7", 20, 21, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 0);
    step("R7", 20, 21, 0, 0, 0, 0, 1);

    // R8: same-cycle read returns old value, next cycle the new one
    step("R8", 3, 12, 1, 3, 32'hBEEF_0003, 0, 0);
    step("R8", 3, 3, 0, 0, 0, 0, 0);

    // R9: calls until the saved count is exhausted, then once more
    for (int i = 0; i < NWIN; i++) step("R9", 26, 10, 0, 0, 0, 1, 0);
    // R10: returns until none saved, then once more
    for (int i = 0; i < NWIN; i++) step("R10", 26, 10, 0, 0, 0, 0, 1);

    // R11: call and return together cancel
    step("R11", 0, 0, 0, 0, 0, 1, 1);
    step("R11", 0, 0, 0, 0, 0, 0, 1);
    step("R11", 0, 0, 0, 0, 0, 1, 1);

    // R12: NWIN calls wrap to the same window
    step("R12", 0, 0, 1, 18, 32'h1200_0018, 0, 0);
    for (int i = 0; i < NWIN; i++) step("R12", 18, 28, 0, 0, 0, 1, 0);
    step("R12", 18, 28, 0, 0, 0, 0, 0);

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int u = $urandom % 100;
      bit c = (u < 22) || (u >= 97);
      bit r = ((u >= 22) && (u < 40)) || (u >= 97);
      step("R4", $urandom % 32, $urandom % 32, ($urandom % 2) == 1, $urandom % 32,
           $urandom, c, r);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule